// File: doc/BRIEF.md
# Microcoded Accumulator Operate Unit

This unit carries out operate-class instruction words for a small accumulator machine. One such word can hold several accumulator and link micro-operations at once. The unit applies them in three fixed slots in a single cycle. In the first slot it clears, in the second it complements, and in the third it increments and then merges in the data switches. The slot order means that some combinations act as derived operations. Examples are load all ones, two's-complement negate, and load switches.

The surrounding processor presents an instruction word together with the current accumulator, link and data-switch value, and pulses a valid strobe. The unit registers the new accumulator and link on that clock edge. An operate word with its top bit clear also raises a halt request. The halt request stays asserted until a restart input clears it. Words outside the operate class are ignored.

Top module: `opr_unit`

## Requirements
- R1: After reset, acc_o is 0, link_o is 0 and halt_o is 0.
- R2: A word is operate-class only when bits 14 down to 6 are all zero. A word that fails this test, or any cycle with valid_i low, leaves acc_o, link_o and halt_o unchanged.
- R3: Slot one runs first. Bit 0 clears the accumulator and bit 3 clears the link.
- R4: Slot two acts on the slot-one result. Bit 1 inverts every accumulator bit and bit 4 inverts the link.
- R5: Slot three acts on the slot-two result. Bit 2 adds one to the accumulator modulo 2^16, and a carry out of bit 15 toggles the link. After that, bit 5 ORs dswitch_i into the accumulator.
- R6: Because of the slot order, 0o100003 yields 0xFFFF, 0o100006 yields the two's-complement negation of acc_i, and 0o100041 yields dswitch_i.
- R7: Results appear on acc_o and link_o after the clock edge at which valid_i is sampled high. The outputs do not change before that edge, and every operate word takes exactly one cycle.
- R8: An operate word with bit 15 clear still applies its micro-operations, and sets halt_o on the same edge.
- R9: halt_o holds until restart_i is sampled high, which clears it. If a halting operate word arrives in the same cycle as restart_i, halt_o is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word and operands are valid this cycle |
| instr_i | input | 16 | Instruction word |
| acc_i | input | 16 | Current accumulator |
| link_i | input | 1 | Current link bit |
| dswitch_i | input | 16 | Data-switch value |
| restart_i | input | 1 | Clears the halt request |
| acc_o | output | 16 | Registered next accumulator |
| link_o | output | 1 | Registered next link |
| halt_o | output | 1 | Sticky halt request |

## Verification
The bench sweeps all 64 micro-bit patterns against both halt-bit values, both link values and edge accumulator values such as 0xFFFF and 0x8000. This coverage catches three kinds of fault:
- A slot swap would produce 0x0000 instead of 0xFFFF for clear-then-complement.
- An increment carry that loads the link instead of toggling it would give the wrong link value.
- An OR applied before the increment would give the wrong accumulator value.

Separate checks cover the halt behaviour. They confirm that halt_o survives idle cycles and non-halting words, that restart_i clears it, and that a set in the same cycle beats a restart. Words with stray class bits are also sent; a decoder that tested too few bits would act on them and change the outputs.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int unsigned OPR_W = 16;

  typedef struct packed {
    logic halt;
    logic clr_acc;
    logic clr_link;
    logic cmp_acc;
    logic cmp_link;
    logic inc_acc;
    logic or_sw;
  } micro_t;
endpackage

// File: rtl/opr_decode.sv
module opr_decode #(
  parameter int unsigned DATA_W = opr_pkg::OPR_W
) (
  input  logic [DATA_W-1:0] word_i,
  output logic              is_opr_o,
  output opr_pkg::micro_t   micro_o
);
  localparam int unsigned CLS_LO = 6;
  localparam int unsigned CLS_HI = DATA_W - 2;
  localparam int unsigned HLT_B  = DATA_W - 1;

  always_comb begin
    is_opr_o         = ~|word_i[CLS_HI:CLS_LO];
    micro_o.halt     = ~word_i[HLT_B];
    micro_o.clr_acc  = word_i[0];
    micro_o.cmp_acc  = word_i[1];
    micro_o.inc_acc  = word_i[2];
    micro_o.clr_link = word_i[3];
    micro_o.cmp_link = word_i[4];
    micro_o.or_sw    = word_i[5];
  end
endmodule

// File: rtl/opr_slot_path.sv
module opr_slot_path #(
  parameter int unsigned DATA_W = opr_pkg::OPR_W
) (
  input  opr_pkg::micro_t   micro_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  input  logic [DATA_W-1:0] sw_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              link_o
);
  logic [DATA_W-1:0] t1_acc, t2_acc, t3_acc;
  logic              t1_link, t2_link, t3_link;
  logic [DATA_W:0]   inc_sum;

  always_comb begin
    // slot 1: clears
    t1_acc  = micro_i.clr_acc  ? '0 : acc_i;
    t1_link = micro_i.clr_link ? 1'b0 : link_i;
    // slot 2: complements
    t2_acc  = micro_i.cmp_acc  ? ~t1_acc : t1_acc;
    t2_link = micro_i.cmp_link ? ~t1_link : t1_link;
    // slot 3: increment (carry toggles link), then switch merge
    inc_sum = {1'b0, t2_acc} + {{DATA_W{1'b0}}, 1'b1};
    t3_acc  = micro_i.inc_acc ? inc_sum[DATA_W-1:0] : t2_acc;
    t3_link = t2_link ^ (micro_i.inc_acc & inc_sum[DATA_W]);
    acc_o   = micro_i.or_sw ? (t3_acc | sw_i) : t3_acc;
    link_o  = t3_link;
  end
endmodule

// File: rtl/opr_unit.sv
module opr_unit #(
  parameter int unsigned DATA_W = opr_pkg::OPR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              link_i,
  input  logic [DATA_W-1:0] dswitch_i,
  input  logic              restart_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              link_o,
  output logic              halt_o
);
  opr_pkg::micro_t   micro;
  logic              is_opr;
  logic              take;
  logic [DATA_W-1:0] nxt_acc;
  logic              nxt_link;

  opr_decode #(.DATA_W(DATA_W)) u_dec (
    .word_i  (instr_i),
    .is_opr_o(is_opr),
    .micro_o (micro)
  );

  opr_slot_path #(.DATA_W(DATA_W)) u_path (
    .micro_i(micro),
    .acc_i  (acc_i),
    .link_i (link_i),
    .sw_i   (dswitch_i),
    .acc_o  (nxt_acc),
    .link_o (nxt_link)
  );

  assign take = valid_i & is_opr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      link_o <= 1'b0;
    end else if (take) begin
      acc_o  <= nxt_acc;
      link_o <= nxt_link;
    end
  end

  // set beats restart in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                halt_o <= 1'b0;
    else if (take & micro.halt) halt_o <= 1'b1;
    else if (restart_i)         halt_o <= 1'b0;
  end

  a_r2_ignore_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> ($stable(acc_o) && $stable(link_o)));
  a_r2_ignore_no_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take && !restart_i) |=> $stable(halt_o));
  a_r8_halt_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_opr && !instr_i[DATA_W-1]) |=> halt_o);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !restart_i) |=> halt_o);
  a_r9_restart_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !(valid_i && is_opr && !instr_i[DATA_W-1])) |=> !halt_o);
  a_r6_load_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i == 16'o100003) |=> (acc_o == '1));
  a_r6_load_switches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i == 16'o100041) |=> (acc_o == $past(dswitch_i)));
endmodule

// File: tb/opr_unit_bench.sv
module opr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] acc_in = '0;
  logic        link_in = 1'b0;
  logic [15:0] sw = '0;
  logic        restart = 1'b0;
  logic [15:0] acc_out;
  logic        link_out;
  logic        halt_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  opr_unit u_opr_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .acc_i(acc_in), .link_i(link_in), .dswitch_i(sw), .restart_i(restart),
    .acc_o(acc_out), .link_o(link_out), .halt_o(halt_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // arithmetic reference: returns {link, acc}
  function automatic logic [16:0] model(input logic [5:0] m, input int a, input int l, input int s);
    int aa = a;
    int ll = l;
    if (m[0]) aa = 0;
    if (m[3]) ll = 0;
    if (m[1]) aa = 65535 - aa;
    if (m[4]) ll = 1 - ll;
    if (m[2]) begin
      if (aa == 65535) begin aa = 0; ll = 1 - ll; end
      else aa = aa + 1;
    end
    if (m[5]) aa = aa | s;
    return {ll[0], aa[15:0]};
  endfunction

  task automatic drive(input logic [15:0] w, input logic [15:0] a, input logic l,
                       input logic [15:0] s, input logic v, input logic r);
    @(negedge clk);
    instr = w; acc_in = a; link_in = l; sw = s; valid = v; restart = r;
    @(negedge clk);
    valid = 1'b0; restart = 1'b0;
  endtask

  initial begin
    logic [15:0] avals [6];
    logic [16:0] e;
    logic [15:0] keep_acc;
    logic        keep_link;
    avals[0] = 16'h0000; avals[1] = 16'h0001; avals[2] = 16'h7FFF;
    avals[3] = 16'h8000; avals[4] = 16'hFFFF; avals[5] = 16'h1234;

    #12;
    chk("R1 acc", acc_out, 0);
    chk("R1 link", link_out, 0);
    chk("R1 halt", halt_out, 0);
    rst_n = 1'b1;

    // full sweep; restart high each time so halt follows bit 15 (R8, R9)
    for (int m = 0; m < 64; m++)
      for (int h = 0; h < 2; h++)
        for (int l = 0; l < 2; l++)
          for (int k = 0; k < 6; k++) begin
            logic [15:0] s;
            logic [15:0] w;
            s = 16'h0F0F ^ (16'(k) << 4) ^ 16'(m);
            w = {h[0], 9'd0, m[5:0]};
            e = model(m[5:0], int'(avals[k]), l, int'(s));
            drive(w, avals[k], l[0], s, 1'b1, 1'b1);
            chk("R3 R4 R5 acc", acc_out, e[15:0]);
            chk("R3 R4 R5 link", link_out, e[16]);
            chk("R8 halt", halt_out, h == 0);
          end

    // derived codes (R6)
    drive(16'o100003, 16'h5A5A, 1'b0, 16'h0000, 1'b1, 1'b1);
    chk("R6 ones", acc_out, 16'hFFFF);
    drive(16'o100006, 16'h0005, 1'b0, 16'h0000, 1'b1, 1'b1);
    chk("R6 negate", acc_out, 16'hFFFB);
    drive(16'o100006, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1);
    chk("R6 negate zero", acc_out, 16'h0000);
    chk("R6 negate zero link", link_out, 1);
    drive(16'o100041, 16'hBEEF, 1'b1, 16'hC3A5, 1'b1, 1'b1);
    chk("R6 switches", acc_out, 16'hC3A5);

    // timing: no change before edge, new value after (R7)
    @(negedge clk);
    instr = 16'o100002; acc_in = 16'h00F0; link_in = 1'b0; valid = 1'b1;
    #3;
    chk("R7 before edge", acc_out, 16'hC3A5);
    @(negedge clk);
    valid = 1'b0;
    chk("R7 after edge", acc_out, 16'hFF0F);

    // halt sticky (R9)
    drive(16'o000000, 16'h1111, 1'b1, 16'h0, 1'b1, 1'b0);
    chk("R8 halt word", halt_out, 1);
    chk("R8 no-op acc", acc_out, 16'h1111);
    repeat (3) @(negedge clk);
    chk("R9 sticky idle", halt_out, 1);
    drive(16'o100000, 16'h2222, 1'b0, 16'h0, 1'b1, 1'b0);
    chk("R9 sticky run word", halt_out, 1);
    drive(16'o100000, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1);
    chk("R9 restart clears", halt_out, 0);
    drive(16'o000001, 16'h3333, 1'b0, 16'h0, 1'b1, 1'b1);
    chk("R9 set beats restart", halt_out, 1);
    drive(16'o100000, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1);
    chk("R9 restart clears again", halt_out, 0);

    // ignored words and valid low (R2)
    keep_acc = acc_out; keep_link = link_out;
    for (int b = 6; b < 15; b++) begin
      drive(16'o000077 | (16'h1 << b), 16'hAAAA, ~keep_link, 16'hFFFF, 1'b1, 1'b0);
      chk("R2 non-operate acc", acc_out, keep_acc);
      chk("R2 non-operate link", link_out, keep_link);
      chk("R2 non-operate halt", halt_out, 0);
    end
    drive(16'o000001, 16'h5555, ~keep_link, 16'h0, 1'b0, 1'b0);
    chk("R2 valid low acc", acc_out, keep_acc);
    chk("R2 valid low halt", halt_out, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule